// File: doc/BRIEF.md
# Isochronous Transmit Packing Controller

This block decides, once per bus cycle, what isochronous packet to send and then streams it out one quadlet per clock. On each cycle-start strobe it looks at how many quadlets wait in a first-word-fall-through transmit FIFO. From the packing mode and a maximum block count it works out how many data blocks go into the payload. It then emits a header quadlet, followed by an optional time stamp quadlet taken from the FIFO, and then the payload quadlets read from the FIFO in order.

Software drives the block through one configuration write port. The fields are a soft-reset bit, an enable bit, the packing mode, the maximum block count and an external-time-stamp flag. The soft-reset bit powers up set, so the transmitter starts held in reset. Clearing enable lets the packet in flight complete. Setting soft reset stops output at once and flushes the FIFO. While the transmitter is enabled, the packing fields are locked, and any write that tries to change them is dropped and latches an error flag.

A data block is `2**BLK_LOG2` quadlets. The header quadlet carries the block count in bits 31:24, the block size in quadlets in bits 23:16, the mode in bits 15:14 and a time-stamp-follows flag in bit 13. All other header bits are zero.

Top module: `iso_tx_packer`

## Requirements
- R1: After `rst`, `pkt_valid` and `fifo_rd` are low, `cfg_err` is low and `fifo_flush` is high, because the transmitter powers up held in soft reset.
- R2: A `cyc_start` accepted while the transmitter is enabled, out of soft reset and idle produces a header quadlet on the next cycle with `pkt_sop` high. The packet then continues on consecutive cycles, and `pkt_eop` marks its last quadlet. A packet with zero blocks is the header alone, with `pkt_sop` and `pkt_eop` both high.
- R3: In mode 2'b00 (variable) and mode 2'b10 (MPEG-2), the block count is the smaller of the maximum block count and the whole blocks in the FIFO.
- R4: In mode 2'b01 (fixed), the block count is the maximum block count when the FIFO holds at least that many whole blocks. Otherwise it is zero.
- R5: In mode 2'b11, every packet is a header with zero blocks. No time stamp is sent and no FIFO read occurs, even when the time stamp flag is set.
- R6: With the external time stamp flag set, a packet with one or more blocks carries the first FIFO quadlet as a time stamp right after the header, and that quadlet is not counted toward the blocks. A packet with zero blocks carries no time stamp.
- R7: Payload quadlets appear in FIFO order. `fifo_rd` is high exactly one cycle before each time stamp or payload quadlet appears, and at no other time.
- R8: A `cyc_start` that arrives while a packet is still being emitted is ignored.
- R9: Writing enable low lets the packet in progress run to its `pkt_eop`. No new packet starts afterwards.
- R10: While the soft-reset bit is set, `fifo_flush` is high and `fifo_rd` is low. Output stops on the cycle after the bit is seen, without an end marker, and `cyc_start` is ignored.
- R11: While enabled, a write that changes the mode or the time stamp flag, or that changes the maximum block count outside mode 2'b10, leaves those fields as they were. Such a write sets `cfg_err`, which stays set until `rst`.
- R12: In mode 2'b10, the maximum block count can be rewritten while enabled. The new count takes effect and `cfg_err` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Bus cycle start strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_soft_rst | input | 1 | Soft reset bit written |
| cfg_enable | input | 1 | Enable bit written |
| cfg_mode | input | 2 | Packing mode written |
| cfg_maxbl | input | 8 | Maximum block count written |
| cfg_ts_ext | input | 1 | External time stamp flag written |
| cfg_err | output | 1 | Sticky error flag for locked-field writes |
| fifo_level | input | LVL_W | Quadlets held in the transmit FIFO |
| fifo_data | input | 32 | Head quadlet of the FIFO (fall-through) |
| fifo_rd | output | 1 | Pop the FIFO head at this edge |
| fifo_flush | output | 1 | Empty the FIFO (soft reset active) |
| pkt_valid | output | 1 | Output quadlet valid |
| pkt_sop | output | 1 | First quadlet (header) of a packet |
| pkt_eop | output | 1 | Last quadlet of a packet |
| pkt_data | output | 32 | Output quadlet |

## Verification
The bench builds the block with two-quadlet blocks (`BLK_LOG2` = 1) and an 8-bit FIFO level. Odd FIFO counts therefore leave a partial block, which tests the truncation to whole blocks and the way the time stamp quadlet is set aside before blocks are counted. Small maximum block counts (1 to 4) keep packets short. This lets the fixed-mode threshold be crossed in both directions, and lets disable and soft reset land in the middle of a packet, with a cycle-by-cycle model compared on every clock.

// File: rtl/iso_tx_packer_pkg.sv
package iso_tx_packer_pkg;

  typedef enum logic [1:0] {
    PK_VAR   = 2'b00,
    PK_FIXED = 2'b01,
    PK_MPEG  = 2'b10,
    PK_HDR   = 2'b11
  } pk_mode_e;

  typedef enum logic {
    EM_IDLE = 1'b0,
    EM_DATA = 1'b1
  } em_state_e;

  function automatic logic [31:0] hdr_pack(input logic [7:0] nblk,
                                           input logic [7:0] bq,
                                           input logic [1:0] mode,
                                           input logic       ts);
    return {nblk, bq, mode, ts, 13'd0};
  endfunction

endpackage

// File: rtl/itp_ctl_regs.sv
module itp_ctl_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_soft_rst,
  input  logic       wr_enable,
  input  logic [1:0] wr_mode,
  input  logic [7:0] wr_maxbl,
  input  logic       wr_ts_ext,
  output logic       tx_rst,
  output logic       tx_en,
  output logic [1:0] mode,
  output logic [7:0] maxbl,
  output logic       ts_ext,
  output logic       err
);
  import iso_tx_packer_pkg::*;

  logic live_mb;
  logic lock_hit;

  assign live_mb  = (mode == PK_MPEG);
  assign lock_hit = (wr_mode != mode) || (wr_ts_ext != ts_ext) ||
                    (!live_mb && (wr_maxbl != maxbl));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rst <= 1'b1;
      tx_en  <= 1'b0;
      mode   <= PK_VAR;
      maxbl  <= '0;
      ts_ext <= 1'b0;
      err    <= 1'b0;
    end else if (wr_en) begin
      tx_rst <= wr_soft_rst;
      tx_en  <= wr_enable;
      if (!tx_en) begin
        mode   <= wr_mode;
        maxbl  <= wr_maxbl;
        ts_ext <= wr_ts_ext;
      end else begin
        if (live_mb) maxbl <= wr_maxbl;
        if (lock_hit) err <= 1'b1;
      end
    end
  end

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  p_mode_locked_r11: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> ($stable(mode) && $stable(ts_ext)));
  p_maxbl_locked_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_en && mode != PK_MPEG) |=> $stable(maxbl));
  p_maxbl_live_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tx_en && mode == PK_MPEG) |=> (maxbl == $past(wr_maxbl)));

endmodule

// File: rtl/itp_sizer.sv
module itp_sizer #(
  parameter int LVL_W    = 12,
  parameter int BLK_LOG2 = 1,
  localparam int LEN_W   = 8 + BLK_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [7:0]       maxbl,
  input  logic             ts_ext,
  input  logic [LVL_W-1:0] level,
  output logic [7:0]       nblk,
  output logic             ts_on,
  output logic [LEN_W-1:0] pkt_len,
  output logic [31:0]      hdr
);
  import iso_tx_packer_pkg::*;

  localparam int CW       = ((LVL_W > 8) ? LVL_W : 8) + 1;
  localparam logic [7:0] BQ8 = 8'(1 << BLK_LOG2);

  logic [LVL_W-1:0] lvl_dat;
  logic [LVL_W-1:0] avail;
  logic [CW-1:0]    av_w;
  logic [CW-1:0]    mb_w;
  logic             enough;

  always_comb begin
    if (!ts_ext)           lvl_dat = level;
    else if (level != '0)  lvl_dat = level - LVL_W'(1);
    else                   lvl_dat = '0;
    avail  = lvl_dat >> BLK_LOG2;
    av_w   = CW'(avail);
    mb_w   = CW'(maxbl);
    enough = (av_w >= mb_w);
    case (pk_mode_e'(mode))
      PK_HDR:   nblk = '0;
      PK_FIXED: nblk = enough ? maxbl : 8'd0;
      default:  nblk = enough ? maxbl : av_w[7:0];
    endcase
    ts_on   = ts_ext && (nblk != '0);
    pkt_len = LEN_W'(1) + LEN_W'(ts_on) + (LEN_W'(nblk) << BLK_LOG2);
    hdr     = hdr_pack(nblk, BQ8, mode, ts_on);
  end

  p_fit_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(nblk) * (1 << BLK_LOG2) + int'(ts_on)) <= int'(level));
  p_cap_r3: assert property (@(posedge clk) disable iff (rst)
    nblk <= maxbl);

endmodule

// File: rtl/itp_emitter.sv
module itp_emitter #(
  parameter int LVL_W    = 12,
  parameter int BLK_LOG2 = 1,
  localparam int LEN_W   = 8 + BLK_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_rst,
  input  logic             tx_en,
  input  logic             cyc_start,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [31:0]      hdr,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [31:0]      fifo_data,
  output logic             fifo_rd,
  output logic             pkt_valid,
  output logic             pkt_sop,
  output logic             pkt_eop,
  output logic [31:0]      pkt_data
);
  import iso_tx_packer_pkg::*;

  em_state_e        state;
  logic [LEN_W-1:0] rem;

  assign fifo_rd = (state == EM_DATA) && !tx_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= EM_IDLE;
      rem       <= '0;
      pkt_valid <= 1'b0;
      pkt_sop   <= 1'b0;
      pkt_eop   <= 1'b0;
      pkt_data  <= '0;
    end else if (tx_rst) begin
      state     <= EM_IDLE;
      rem       <= '0;
      pkt_valid <= 1'b0;
      pkt_sop   <= 1'b0;
      pkt_eop   <= 1'b0;
    end else begin
      case (state)
        EM_IDLE: begin
          if (tx_en && cyc_start) begin
            pkt_valid <= 1'b1;
            pkt_sop   <= 1'b1;
            pkt_eop   <= (pkt_len == LEN_W'(1));
            pkt_data  <= hdr;
            rem       <= pkt_len - LEN_W'(1);
            state     <= (pkt_len == LEN_W'(1)) ? EM_IDLE : EM_DATA;
          end else begin
            pkt_valid <= 1'b0;
            pkt_sop   <= 1'b0;
            pkt_eop   <= 1'b0;
          end
        end
        default: begin
          pkt_valid <= 1'b1;
          pkt_sop   <= 1'b0;
          pkt_data  <= fifo_data;
          pkt_eop   <= (rem == LEN_W'(1));
          rem       <= rem - LEN_W'(1);
          if (rem == LEN_W'(1)) state <= EM_IDLE;
        end
      endcase
    end
  end

  p_sop_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    pkt_sop |-> $past(cyc_start));
  p_rd_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (fifo_level != '0));
  p_no_start_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && state == EM_IDLE) |=> !pkt_sop);
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (state == EM_DATA && !tx_rst) |=> !pkt_sop);

endmodule

// File: rtl/iso_tx_packer.sv
module iso_tx_packer #(
  parameter int LVL_W    = 12,
  parameter int BLK_LOG2 = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             cfg_we,
  input  logic             cfg_soft_rst,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_mode,
  input  logic [7:0]       cfg_maxbl,
  input  logic             cfg_ts_ext,
  output logic             cfg_err,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [31:0]      fifo_data,
  output logic             fifo_rd,
  output logic             fifo_flush,
  output logic             pkt_valid,
  output logic             pkt_sop,
  output logic             pkt_eop,
  output logic [31:0]      pkt_data
);
  localparam int LEN_W = 8 + BLK_LOG2 + 2;

  logic             tx_rst, tx_en, ts_ext, ts_on;
  logic [1:0]       mode;
  logic [7:0]       maxbl, nblk;
  logic [LEN_W-1:0] pkt_len;
  logic [31:0]      hdr;

  itp_ctl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_soft_rst(cfg_soft_rst),
    .wr_enable(cfg_enable), .wr_mode(cfg_mode), .wr_maxbl(cfg_maxbl),
    .wr_ts_ext(cfg_ts_ext), .tx_rst(tx_rst), .tx_en(tx_en), .mode(mode),
    .maxbl(maxbl), .ts_ext(ts_ext), .err(cfg_err)
  );

  itp_sizer #(.LVL_W(LVL_W), .BLK_LOG2(BLK_LOG2)) u_sizer (
    .clk(clk), .rst(rst), .mode(mode), .maxbl(maxbl), .ts_ext(ts_ext),
    .level(fifo_level), .nblk(nblk), .ts_on(ts_on), .pkt_len(pkt_len),
    .hdr(hdr)
  );

  itp_emitter #(.LVL_W(LVL_W), .BLK_LOG2(BLK_LOG2)) u_emit (
    .clk(clk), .rst(rst), .tx_rst(tx_rst), .tx_en(tx_en),
    .cyc_start(cyc_start), .pkt_len(pkt_len), .hdr(hdr),
    .fifo_level(fifo_level), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
    .pkt_data(pkt_data)
  );

  assign fifo_flush = tx_rst;

  p_sop_valid_r2: assert property (@(posedge clk) disable iff (rst)
    pkt_sop |-> pkt_valid);
  p_eop_valid_r2: assert property (@(posedge clk) disable iff (rst)
    pkt_eop |-> pkt_valid);
  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |=> !pkt_valid);
  p_hdr_only_r5: assert property (@(posedge clk) disable iff (rst)
    (pkt_sop && pkt_data[15:14] == 2'b11) |-> (pkt_eop && pkt_data[31:24] == 8'd0));

endmodule

// File: tb/iso_tx_packer_bench.sv
module iso_tx_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 8;
  localparam int BLK_LOG2   = 1;
  localparam int BQ         = 1 << BLK_LOG2;

  typedef struct { logic [31:0] d; logic e; } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, cfg_we = 1'b0, cfg_soft_rst = 1'b0, cfg_enable = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cfg_maxbl = 8'd0;
  logic cfg_ts_ext = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [31:0] fifo_data = '0;
  logic cfg_err, fifo_rd, fifo_flush, pkt_valid, pkt_sop, pkt_eop;
  logic [31:0] pkt_data;

  iso_tx_packer #(.LVL_W(LVL_W), .BLK_LOG2(BLK_LOG2)) u_iso_tx_packer (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cfg_we(cfg_we),
    .cfg_soft_rst(cfg_soft_rst), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cfg_maxbl(cfg_maxbl), .cfg_ts_ext(cfg_ts_ext), .cfg_err(cfg_err),
    .fifo_level(fifo_level), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .fifo_flush(fifo_flush), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .pkt_data(pkt_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  logic [31:0] fifo_q[$];
  item_t expq[$];
  int seed = 0;
  bit m_rst = 1, m_en = 0, m_ts = 0, m_err = 0;
  logic [1:0] m_mode = 0;
  logic [7:0] m_maxbl = 0;
  bit e_valid, e_sop, e_eop;
  logic [31:0] e_data;
  int hdr_cnt = 0, eop_cnt = 0, rd_cnt = 0, cur_len = 0, last_len = 0;
  logic [31:0] last_hdr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_rst = 1; m_en = 0; m_mode = 0; m_maxbl = 0; m_ts = 0; m_err = 0;
      expq.delete(); fifo_q.delete();
      e_valid = 0; e_sop = 0; e_eop = 0;
      return;
    end
    if (m_rst) begin
      expq.delete(); fifo_q.delete();
      e_valid = 0; e_sop = 0; e_eop = 0;
    end else if (expq.size() > 0) begin
      item_t it = expq.pop_front();
      void'(fifo_q.pop_front());
      e_valid = 1; e_sop = 0; e_eop = it.e; e_data = it.d;
    end else if (m_en && cyc_start) begin
      int lvl = fifo_q.size();
      int dl, av, nb, nitems;
      bit ts;
      dl = m_ts ? ((lvl > 0) ? lvl - 1 : 0) : lvl;
      av = dl / BQ;
      if (m_mode == 2'b11) nb = 0;
      else if (m_mode == 2'b01) nb = (av >= m_maxbl) ? int'(m_maxbl) : 0;
      else nb = (av < m_maxbl) ? av : int'(m_maxbl);
      ts = m_ts && nb > 0;
      nitems = int'(ts) + nb * BQ;
      e_valid = 1; e_sop = 1; e_eop = (nitems == 0);
      e_data = {8'(nb), 8'(BQ), m_mode, ts, 13'd0};
      for (int k = 0; k < nitems; k++) begin
        item_t it;
        it.d = fifo_q[k]; it.e = (k == nitems - 1);
        expq.push_back(it);
      end
    end else begin
      e_valid = 0; e_sop = 0; e_eop = 0;
    end
    if (cfg_we) begin
      if (m_en) begin
        if (cfg_mode != m_mode || cfg_ts_ext != m_ts ||
            (m_mode != 2'b10 && cfg_maxbl != m_maxbl)) m_err = 1;
        if (m_mode == 2'b10) m_maxbl = cfg_maxbl;
      end else begin
        m_mode = cfg_mode; m_maxbl = cfg_maxbl; m_ts = cfg_ts_ext;
      end
      m_rst = cfg_soft_rst; m_en = cfg_enable;
    end
  endtask

  task automatic drive_fifo();
    fifo_level = LVL_W'(fifo_q.size());
    fifo_data = (fifo_q.size() > 0) ? fifo_q[0] : 32'd0;
  endtask

  task automatic tick();
    @(negedge clk);
    model_edge();
    chk(pkt_valid == e_valid, cur_req, "pkt_valid", 32'(pkt_valid), 32'(e_valid));
    if (e_valid && pkt_valid) begin
      chk(pkt_sop == e_sop, cur_req, "pkt_sop", 32'(pkt_sop), 32'(e_sop));
      chk(pkt_eop == e_eop, cur_req, "pkt_eop", 32'(pkt_eop), 32'(e_eop));
      chk(pkt_data == e_data, cur_req, "pkt_data", pkt_data, e_data);
    end
    chk(fifo_flush == m_rst, cur_req, "fifo_flush", 32'(fifo_flush), 32'(m_rst));
    chk(cfg_err == m_err, cur_req, "cfg_err", 32'(cfg_err), 32'(m_err));
    chk(fifo_rd == (expq.size() > 0 && !m_rst), cur_req, "fifo_rd",
        32'(fifo_rd), 32'(expq.size() > 0 && !m_rst));
    if (pkt_valid) begin
      if (pkt_sop) begin hdr_cnt++; last_hdr = pkt_data; cur_len = 0; end
      cur_len++;
      if (pkt_eop) begin eop_cnt++; last_len = cur_len; end
    end
    if (fifo_rd) rd_cnt++;
    cfg_we = 0; cyc_start = 0;
    drive_fifo();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wcfg(input bit r, input bit en, input logic [1:0] md,
                      input logic [7:0] mb, input bit ts);
    cfg_we = 1; cfg_soft_rst = r; cfg_enable = en; cfg_mode = md;
    cfg_maxbl = mb; cfg_ts_ext = ts;
    tick();
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      seed++;
      fifo_q.push_back(32'hA500_0000 + 32'(seed));
    end
    drive_fifo();
  endtask

  task automatic pkt(input int settle);
    cyc_start = 1;
    tick();
    run(settle);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int h0, r0, e0;
    cur_req = "R1";
    rst = 1; run(3);
    rst = 0; tick();
    chk(!pkt_valid && fifo_flush && !cfg_err && !fifo_rd, "R1", "reset state",
        {28'd0, pkt_valid, fifo_flush, cfg_err, fifo_rd}, 32'h4);

    cur_req = "R10";
    h0 = hdr_cnt; push(4); pkt(3);
    chk(hdr_cnt == h0, "R10", "start ignored in soft reset", 32'(hdr_cnt), 32'(h0));

    cur_req = "R3";
    wcfg(0, 1, 2'b00, 8'd3, 0);
    push(5); r0 = rd_cnt; pkt(8);
    chk(last_hdr[31:24] == 8'd2, "R3", "variable nblk", 32'(last_hdr[31:24]), 32'd2);
    chk(rd_cnt - r0 == 4, "R7", "reads for 2 blocks", 32'(rd_cnt - r0), 32'd4);

    cur_req = "R8";
    push(10); h0 = hdr_cnt;
    cyc_start = 1; tick(); tick(); cyc_start = 1; tick(); run(8);
    chk(hdr_cnt == h0 + 1, "R8", "start during packet", 32'(hdr_cnt), 32'(h0 + 1));
    chk(last_hdr[31:24] == 8'd3, "R3", "nblk capped at max", 32'(last_hdr[31:24]), 32'd3);

    cur_req = "R2";
    pkt(6); pkt(3);
    chk(last_hdr[31:24] == 8'd0 && last_len == 1, "R2", "header-only length",
        32'(last_len), 32'd1);

    cur_req = "R4";
    wcfg(0, 0, 2'b00, 8'd3, 0);
    wcfg(0, 0, 2'b01, 8'd4, 0);
    wcfg(0, 1, 2'b01, 8'd4, 0);
    push(4); pkt(3);
    chk(last_hdr[31:24] == 8'd0, "R4", "fixed short fifo", 32'(last_hdr[31:24]), 32'd0);
    push(4); pkt(10);
    chk(last_hdr[31:24] == 8'd4, "R4", "fixed full", 32'(last_hdr[31:24]), 32'd4);

    cur_req = "R5";
    wcfg(0, 0, 2'b01, 8'd4, 0);
    wcfg(0, 1, 2'b11, 8'd4, 1);
    push(6); r0 = rd_cnt; pkt(4);
    chk(rd_cnt == r0 && last_hdr[13] == 1'b0, "R5", "header-only mode reads",
        32'(rd_cnt - r0), 32'd0);

    cur_req = "R6";
    wcfg(1, 0, 2'b11, 8'd4, 1);
    run(2);
    wcfg(0, 0, 2'b00, 8'd4, 1);
    wcfg(0, 1, 2'b00, 8'd4, 1);
    push(1); pkt(3);
    chk(last_hdr[13] == 1'b0 && last_hdr[31:24] == 0, "R6", "no stamp on empty",
        last_hdr, 32'h0);
    push(4); pkt(8);
    chk(last_hdr[13] == 1'b1 && last_hdr[31:24] == 8'd2, "R6", "stamp + 2 blocks",
        {last_hdr[31:24], 23'd0, last_hdr[13]}, 32'h0200_0001);
    chk(last_len == 6, "R6", "length with stamp", 32'(last_len), 32'd6);

    cur_req = "R12";
    rst = 1; tick(); rst = 0; tick();
    wcfg(0, 0, 2'b10, 8'd1, 0);
    wcfg(0, 1, 2'b10, 8'd1, 0);
    wcfg(0, 1, 2'b10, 8'd2, 0);
    push(8); pkt(7);
    chk(last_hdr[31:24] == 8'd2 && !cfg_err, "R12", "live max change",
        {last_hdr[31:24], 23'd0, cfg_err}, 32'h0200_0000);

    cur_req = "R11";
    wcfg(0, 1, 2'b00, 8'd2, 0);
    pkt(7);
    chk(cfg_err == 1'b1, "R11", "sticky error", 32'(cfg_err), 32'd1);
    chk(last_hdr[15:14] == 2'b10, "R11", "mode unchanged", 32'(last_hdr[15:14]), 32'd2);

    cur_req = "R9";
    push(8); e0 = eop_cnt;
    cyc_start = 1; tick(); tick();
    wcfg(0, 0, 2'b10, 8'd2, 0);
    run(6);
    chk(eop_cnt == e0 + 1 && last_len == 5, "R9", "packet finishes",
        32'(last_len), 32'd5);
    h0 = hdr_cnt; pkt(3);
    chk(hdr_cnt == h0, "R9", "no start when disabled", 32'(hdr_cnt), 32'(h0));

    cur_req = "R10";
    wcfg(0, 1, 2'b10, 8'd2, 0);
    push(8); e0 = eop_cnt;
    cyc_start = 1; tick(); tick();
    wcfg(1, 1, 2'b10, 8'd2, 0);
    run(6);
    chk(eop_cnt == e0 && !pkt_valid && fifo_flush, "R10", "abort without eop",
        32'(eop_cnt - e0), 32'd0);
    wcfg(0, 1, 2'b10, 8'd2, 0);
    pkt(3);
    chk(last_hdr[31:24] == 8'd0, "R10", "fifo flushed", 32'(last_hdr[31:24]), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule